// File: doc/BRIEF.md
# Five-Pin General-Purpose I/O Port with Stop-Mode Handling

This block controls a small general-purpose I/O port of five pins through a simple byte-wide register bus. It holds three registers: a latch of the output levels, a per-pin direction selector and a pull-up enable for the four lower pins. From them it drives the pad controls: output level, output enable and pull-up enable. Pin input levels are resynchronised into the clock domain and returned on reads of input pins. Output pins return the latched value instead. The top pin is output-only: it has no pull-up, and reading it always returns the latched level.

The port also follows two low-power stop modes. A one-cycle stop request with a mode select picks the mode, and a wake pulse ends it. In the power-down mode every register is wiped to its reset value and every pin goes to high impedance with no pull-up. After wake-up the port looks freshly reset. In the retention mode every register and pin state is kept, and the port resumes exactly as it was. Register writes have no effect while either mode is active.

Top module: `gpio_stop_port`

## Requirements
- R1: After reset all three registers read 0x00 and every bit of pin_oe and pin_pu is 0.
- R2: A write to address 0x00 latches write-data bits 4:0 whatever the directions; pin_out equals the latched value and pin_oe equals the direction register. Bits 7:5 of a read of 0x00 are 0.
- R3: A read of address 0x00 returns, in bit i of pins 0 to 3, the latched bit when direction bit i is 1 (output), and the level of pin_in bit i when it is 0 (input). The input level is the one present two clock edges earlier.
- R4: Pin 4 is output-only: read bit 4 of address 0x00 always returns the latched bit 4, and pin_pu bit 4 is always 0.
- R5: Address 0x01 holds the pull-up enables in bits 3:0, written and read back there; bits 7:4 read as 0.
- R6: pin_pu bit i (i in 0..3) is 1 exactly when pull-up bit i is 1 and direction bit i is 0.
- R7: Address 0x02 holds the direction bits 4:0 (1 = output, 0 = input). Any other address reads 0x00, and writes to it change nothing.
- R8: A stop request with stop_sel = 1 (power-down) clears all registers by the next cycle, so pin_oe, pin_pu and pin_out are all 0. After wake the port reads as after reset.
- R9: A stop request with stop_sel = 0 (retention) keeps all registers and pin controls unchanged through the stop and after wake.
- R10: Writes are ignored while stopped, including in the cycle of the wake pulse. A write in the same cycle as the stop request is still applied, and power-down then wipes it.
- R11: A stop request while already stopped, and a wake pulse while running, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| stop_req | input | 1 | One-cycle stop-mode entry request |
| stop_sel | input | 1 | Mode select with stop_req: 1 power-down, 0 retention |
| wake | input | 1 | Wake pulse ending a stop mode |
| pin_in | input | 5 | Pin input levels |
| pin_out | output | 5 | Pin output levels |
| pin_oe | output | 5 | Pin output enables |
| pin_pu | output | 5 | Pin pull-up enables |

## Verification
Two pairs of functions can fall in the same cycle: a register write together with a stop request, and a register write together with a wake pulse. The bench drives each coincidence in both stop modes. After wake it reads the registers back and predicts the result from the mode. A write beside a retention request must survive. A write beside a power-down request must be gone. A write beside a wake pulse must never land.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int BUS_W = 8;
    localparam logic [BUS_W-1:0] ADDR_LVL = 8'h00;
    localparam logic [BUS_W-1:0] ADDR_PUL = 8'h01;
    localparam logic [BUS_W-1:0] ADDR_DIR = 8'h02;

    typedef enum logic [1:0] {
        PM_RUN = 2'd0,
        PM_KEEP = 2'd1,
        PM_OFF = 2'd2
    } pmode_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = raw;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign synced = sy_q.s2;

    // R3: the read path sees the level two edges old
    p_two_stage_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sy_q.s2 == $past(sy_q.s1)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NPIN = 5,
    parameter int NPU  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    input  logic             stop_req,
    input  logic             stop_sel,
    input  logic             wake,
    output logic [NPIN-1:0]  lvl,
    output logic [NPIN-1:0]  dir,
    output logic [NPU-1:0]   pul
);
    typedef struct packed {
        pmode_e          mode;
        logic [NPIN-1:0] lvl;
        logic [NPIN-1:0] dir;
        logic [NPU-1:0]  pul;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            PM_RUN: begin
                if (bus_wr) begin
                    if (bus_addr == ADDR_LVL) st_d.lvl = bus_wdata[NPIN-1:0];
                    if (bus_addr == ADDR_DIR) st_d.dir = bus_wdata[NPIN-1:0];
                    if (bus_addr == ADDR_PUL) st_d.pul = bus_wdata[NPU-1:0];
                end
                if (stop_req) begin
                    if (stop_sel) begin
                        st_d.mode = PM_OFF;
                        st_d.lvl  = '0;
                        st_d.dir  = '0;
                        st_d.pul  = '0;
                    end else begin
                        st_d.mode = PM_KEEP;
                    end
                end
            end
            PM_KEEP, PM_OFF: begin
                if (wake) st_d.mode = PM_RUN;
            end
            default: st_d.mode = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: PM_RUN, lvl: '0, dir: '0, pul: '0};
        else        st_q <= st_d;
    end

    assign lvl = st_q.lvl;
    assign dir = st_q.dir;
    assign pul = st_q.pul;

    // R8: power-down entry leaves every register cleared
    p_off_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == PM_RUN && stop_req && stop_sel)
        |=> (st_q.lvl == '0 && st_q.dir == '0 && st_q.pul == '0));

    // R9: retention entry without a write keeps all registers
    p_keep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == PM_RUN && stop_req && !stop_sel && !bus_wr)
        |=> ($stable(st_q.lvl) && $stable(st_q.dir) && $stable(st_q.pul)));

    // R10: nothing changes the registers while stopped
    p_stop_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != PM_RUN)
        |=> ($stable(st_q.lvl) && $stable(st_q.dir) && $stable(st_q.pul)));

    // R11: a stop request while stopped does not switch the mode
    p_no_reenter_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != PM_RUN && !wake) |=> $stable(st_q.mode));
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_port_pkg::*;
#(
    parameter int              NPIN     = 5,
    parameter int              NPU      = 4,
    parameter logic [NPIN-1:0] OUT_ONLY = 5'b10000
) (
    input  logic [NPIN-1:0]  lvl,
    input  logic [NPIN-1:0]  dir,
    input  logic [NPU-1:0]   pul,
    input  logic [NPIN-1:0]  synced,
    input  logic [BUS_W-1:0] bus_addr,
    output logic [BUS_W-1:0] bus_rdata,
    output logic [NPIN-1:0]  pin_out,
    output logic [NPIN-1:0]  pin_oe,
    output logic [NPIN-1:0]  pin_pu
);
    logic [NPIN-1:0] rd_lvl;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        if (OUT_ONLY[i]) begin : g_oonly
            assign rd_lvl[i] = lvl[i];
        end else begin : g_bidir
            assign rd_lvl[i] = dir[i] ? lvl[i] : synced[i];
        end
        if (i < NPU && !OUT_ONLY[i]) begin : g_pu
            assign pin_pu[i] = pul[i] & ~dir[i];
        end else begin : g_nopu
            assign pin_pu[i] = 1'b0;
        end
    end

    assign pin_out = lvl;
    assign pin_oe  = dir;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_LVL)      bus_rdata[NPIN-1:0] = rd_lvl;
        else if (bus_addr == ADDR_PUL) bus_rdata[NPU-1:0]  = pul;
        else if (bus_addr == ADDR_DIR) bus_rdata[NPIN-1:0] = dir;
    end

    // R6: a driven pin never has its pull-up on
    p_no_pu_on_out_r6: assert final ((pin_pu & pin_oe) == '0);
    // R2: unimplemented data bits read zero
    p_rsv_zero_r2: assert final ((bus_addr != ADDR_LVL) || (bus_rdata[BUS_W-1:NPIN] == '0));
endmodule

// File: rtl/gpio_stop_port.sv
module gpio_stop_port
    import gpio_port_pkg::*;
#(
    parameter int              NPIN     = 5,
    parameter int              NPU      = 4,
    parameter logic [NPIN-1:0] OUT_ONLY = 5'b10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             stop_req,
    input  logic             stop_sel,
    input  logic             wake,
    input  logic [NPIN-1:0]  pin_in,
    output logic [NPIN-1:0]  pin_out,
    output logic [NPIN-1:0]  pin_oe,
    output logic [NPIN-1:0]  pin_pu
);
    logic [NPIN-1:0] lvl, dir, synced;
    logic [NPU-1:0]  pul;

    gpio_in_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(synced)
    );

    gpio_port_regs #(.NPIN(NPIN), .NPU(NPU)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .stop_req(stop_req), .stop_sel(stop_sel), .wake(wake),
        .lvl(lvl), .dir(dir), .pul(pul)
    );

    gpio_pad_ctl #(.NPIN(NPIN), .NPU(NPU), .OUT_ONLY(OUT_ONLY)) u_pad (
        .lvl(lvl), .dir(dir), .pul(pul), .synced(synced),
        .bus_addr(bus_addr), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    // R4: the output-only pin never gets a pull-up
    p_oonly_nopu_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & OUT_ONLY) == '0);
endmodule

// File: tb/gpio_stop_port_test.sv
`timescale 1ns/1ps
module gpio_stop_port_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_wr = 0;
    logic [7:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;
    logic       stop_req = 0, stop_sel = 0, wake = 0;
    logic [4:0] pin_in = 0;
    logic [4:0] pin_out, pin_oe, pin_pu;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_stop_port uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stop_req(stop_req), .stop_sel(stop_sel), .wake(wake),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    // issue a stop request, optionally with a write in the same cycle
    task automatic stop(input logic sel, input logic w, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        stop_req = 1; stop_sel = sel;
        bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        stop_req = 0; bus_wr = 0;
    endtask

    task automatic wake_up(input logic w, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wake = 1; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        wake = 0; bus_wr = 0;
    endtask

    task automatic check_regs(input string req, input logic [4:0] l, input logic [4:0] dr, input logic [3:0] p);
        logic [7:0] v;
        rd(8'h00, v); chk({req, " lvl out bits"}, v & {3'b000, dr | 5'h10}, {3'b000, l & (dr | 5'h10)});
        rd(8'h01, v); chk({req, " pull"}, v, {4'h0, p});
        rd(8'h02, v); chk({req, " dir"}, v, {3'b000, dr});
        chk({req, " oe"}, {3'b000, pin_oe}, {3'b000, dr});
        chk({req, " out"}, {3'b000, pin_out}, {3'b000, l});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [4:0] exp5;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(8'h00, v); chk("R1 lvl", v, 8'h00);
        rd(8'h01, v); chk("R1 pull", v, 8'h00);
        rd(8'h02, v); chk("R1 dir", v, 8'h00);
        chk("R1 oe", {3'b000, pin_oe}, 8'h00);
        chk("R1 pu", {3'b000, pin_pu}, 8'h00);

        // R2 R3 R4 R5 R6: sweep of directions and pull-up patterns
        for (int dr = 0; dr < 32; dr++) begin
            wr(8'h02, 8'(dr) | 8'he0);
            for (int p = 0; p < 16; p++) begin
                logic [4:0] dat, pins;
                dat  = 5'(dr * 7 + p * 3);
                pins = 5'(~dat ^ 5'(p));
                wr(8'h01, 8'(p) | 8'hf0);
                wr(8'h00, {3'b111, dat});
                @(negedge clk); pin_in = pins;
                repeat (2) @(negedge clk);
                exp5 = (dat & (5'(dr) | 5'h10)) | (pins & ~(5'(dr) | 5'h10));
                rd(8'h00, v); chk("R2 R3 R4 read lvl", v, {3'b000, exp5});
                rd(8'h01, v); chk("R5 pull read", v, {4'h0, 4'(p)});
                rd(8'h02, v); chk("R7 dir read", v, {3'b000, 5'(dr)});
                chk("R2 out", {3'b000, pin_out}, {3'b000, dat});
                chk("R2 oe", {3'b000, pin_oe}, {3'b000, 5'(dr)});
                chk("R6 R4 pu", {3'b000, pin_pu}, {4'h0, 4'(p) & ~4'(dr)});
            end
        end

        // R3: two-edge latency of an input pin
        wr(8'h02, 8'h00);
        @(negedge clk); pin_in = 5'h00;
        repeat (3) @(negedge clk);
        @(negedge clk); pin_in = 5'h0f; bus_addr = 8'h00;
        @(negedge clk); #1 chk("R3 one edge", bus_rdata, 8'h00);
        @(negedge clk); #1 chk("R3 two edges", bus_rdata, 8'h0f);

        // R7: unmapped address
        wr(8'h02, 8'h15); wr(8'h01, 8'h0a); wr(8'h00, 8'h0c);
        wr(8'h03, 8'hff); wr(8'h81, 8'hff);
        rd(8'h03, v); chk("R7 unmapped read", v, 8'h00);
        rd(8'hff, v); chk("R7 unmapped read hi", v, 8'h00);
        check_regs("R7 unmapped write", 5'h0c, 5'h15, 4'ha);

        // R9 retention
        stop(1'b0, 1'b0, 8'h00, 8'h00);
        chk("R9 oe in stop", {3'b000, pin_oe}, 8'h15);
        chk("R9 pu in stop", {3'b000, pin_pu}, 8'h0a);
        wr(8'h00, 8'h1f);  // R10 ignored
        wr(8'h02, 8'h00);
        stop(1'b1, 1'b0, 8'h00, 8'h00); // R11 no mode change
        wake_up(1'b1, 8'h01, 8'h05);   // R10 write with wake ignored
        check_regs("R9 R10 R11 after retention", 5'h0c, 5'h15, 4'ha);
        chk("R9 pu after wake", {3'b000, pin_pu}, 8'h0a);

        // R11 wake while running
        wake_up(1'b0, 8'h00, 8'h00);
        check_regs("R11 wake in run", 5'h0c, 5'h15, 4'ha);

        // R10 write together with a retention request lands
        stop(1'b0, 1'b1, 8'h00, 8'h13);
        wake_up(1'b0, 8'h00, 8'h00);
        check_regs("R10 write with keep stop", 5'h13, 5'h15, 4'ha);

        // R8 power-down
        stop(1'b1, 1'b1, 8'h02, 8'h1f);
        chk("R8 oe cleared", {3'b000, pin_oe}, 8'h00);
        chk("R8 pu cleared", {3'b000, pin_pu}, 8'h00);
        chk("R8 out cleared", {3'b000, pin_out}, 8'h00);
        wr(8'h02, 8'h1f); wr(8'h00, 8'h1f); // R10 ignored
        chk("R10 oe still off", {3'b000, pin_oe}, 8'h00);
        wake_up(1'b1, 8'h02, 8'h1f);
        rd(8'h01, v); chk("R8 pull after wake", v, 8'h00);
        rd(8'h02, v); chk("R8 dir after wake", v, 8'h00);
        chk("R8 oe after wake", {3'b000, pin_oe}, 8'h00);
        chk("R8 out after wake", {3'b000, pin_out}, 8'h00);
        pin_in = 5'h0a;
        repeat (3) @(negedge clk);
        rd(8'h00, v); chk("R8 R4 lvl after wake", v, 8'h0a);

        // port works normally after power-down wake
        wr(8'h02, 8'h03); wr(8'h00, 8'h11);
        rd(8'h00, v); chk("R8 run after wake", v, 8'h19);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule